// File: doc/BRIEF.md
# Pointer-Redirected Data Memory Map

This block is the data space of a small microcontroller core. It covers 128 byte locations, each selected by a 7-bit direct address. The upper half, 40H to 7FH, is general-purpose RAM. Address 01H holds a 7-bit memory pointer. Address 00H has no storage of its own. Any access to 00H is redirected to the location that the pointer selects, which lets software walk through memory by changing the pointer. Addresses 02H to 1FH are handed to an external special-register file, which the core's timer, port and status logic sit behind. The rest of the space below 40H is reserved.

The core reads through a combinational read port and commits through a write port on the rising clock edge. The write port has three operations: a whole-byte store, a single-bit set and a single-bit clear. A bit operation reads the current byte, changes one bit and writes the result back in the same cycle. The pointer redirection applies to all three operations. Both ports are plain control pins with no handshake, because the core issues at most one read and one write per cycle and the block always accepts them.

Top module: `dmem_map`

## Requirements
- R1: A whole-byte store (wr_op=01) to an address in 40H..7FH shows up on rd_data for that address from the cycle after the store. The read port is combinational.
- R2: A read or write at address 00H acts on the location whose address is held in the pointer.
- R3: When the pointer holds 00H, a read at 00H returns 00H, and any write at 00H leaves every location unchanged.
- R4: A write to 01H keeps only data bits 6:0 as the pointer. Reading 01H returns 1 in bit 7 and the pointer in bits 6:0. After reset the pointer is 00H, so 01H reads 80H.
- R5: Addresses 20H..3FH read 00H, and writes to them are ignored.
- R6: For addresses 02H..1FH, reads return ext_rd_data, with ext_rd_addr set to the effective address. Writes pulse ext_wr_en for one cycle, with ext_wr_addr and ext_wr_data set. ext_wr_en stays low for every other region.
- R7: wr_op encodes the write: 00 idle, 01 store wr_data, 10 set bit bit_idx, 11 clear bit bit_idx. A bit operation leaves the other seven bits of the byte unchanged and completes in one clock cycle.
- R8: Bit set and bit clear at address 00H change the byte that the pointer selects.
- R9: When a read and a write hit the same effective location in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointer |
| rd_addr | input | 7 | Direct read address |
| rd_data | output | 8 | Read data, combinational |
| wr_op | input | 2 | Write operation: 00 idle, 01 store, 10 bit set, 11 bit clear |
| wr_addr | input | 7 | Direct write address |
| wr_data | input | 8 | Store data |
| bit_idx | input | 3 | Bit selected by set or clear |
| ext_rd_addr | output | 7 | Effective read address sent to the external registers |
| ext_rd_data | input | 8 | External register read data |
| ext_wr_cur | input | 8 | Current external value at ext_wr_addr, used by bit operations |
| ext_wr_en | output | 1 | External register write strobe |
| ext_wr_addr | output | 7 | Effective write address |
| ext_wr_data | output | 8 | External register write data |

## Verification
A read and a write can fall in the same cycle and resolve to the same byte. They can meet directly, or because one of them goes through 00H while the pointer selects the byte the other one names. A pointer update can also coincide with an indirect read that still uses the old pointer. The bench provokes each case by driving both ports in one cycle. It judges the read value sampled in that cycle against the pre-write contents, and the value read one cycle later against the new contents.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    RG_NULL = 3'd0,
    RG_PTR  = 3'd1,
    RG_EXT  = 3'd2,
    RG_RSV  = 3'd3,
    RG_RAM  = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_STORE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLR   = 2'b11
  } wop_e;
endpackage

// File: rtl/dmem_resolve.sv
module dmem_resolve
  import dmem_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int RAM_BASE = 64,
  parameter int EXT_LO   = 2,
  parameter int EXT_HI   = 31
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] eff,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] RAM_B = RAM_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] EXT_L = EXT_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] EXT_H = EXT_HI[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PTR_A = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    eff = (addr == '0) ? ptr : addr;
    if (eff == '0)                          region = RG_NULL;
    else if (eff == PTR_A)                  region = RG_PTR;
    else if (eff >= RAM_B)                  region = RG_RAM;
    else if (eff >= EXT_L && eff <= EXT_H)  region = RG_EXT;
    else                                    region = RG_RSV;
  end
endmodule

// File: rtl/dmem_pointer.sv
module dmem_pointer #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/dmem_gpram.sv
module dmem_gpram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_dout,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_dout
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= din;
  end

  assign ra_dout = mem[ra_idx];
  assign rb_dout = mem[rb_idx];

  p_store_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(widx)] == $past(din)));
endmodule

// File: rtl/dmem_map.sv
module dmem_map
  import dmem_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 64,
  parameter int RAM_DEPTH = 64,
  parameter int EXT_LO   = 2,
  parameter int EXT_HI   = 31,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int IDX_W   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic [ADDR_W-1:0] ext_rd_addr,
  input  logic [DATA_W-1:0] ext_rd_data,
  input  logic [DATA_W-1:0] ext_wr_cur,
  output logic              ext_wr_en,
  output logic [ADDR_W-1:0] ext_wr_addr,
  output logic [DATA_W-1:0] ext_wr_data
);
  localparam logic [ADDR_W-1:0] RAM_B = RAM_BASE[ADDR_W-1:0];

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] rd_eff, wr_eff, rd_off, wr_off;
  region_e           rd_region, wr_region;
  logic [DATA_W-1:0] ram_rd, ram_wcur, ptr_view;
  logic [DATA_W-1:0] wr_cur, wr_new, bit_mask;
  logic              wr_act, ram_we, ptr_load;

  dmem_resolve #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI))
    u_rd_res (.addr(rd_addr), .ptr(ptr_q), .eff(rd_eff), .region(rd_region));

  dmem_resolve #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI))
    u_wr_res (.addr(wr_addr), .ptr(ptr_q), .eff(wr_eff), .region(wr_region));

  assign rd_off = rd_eff - RAM_B;
  assign wr_off = wr_eff - RAM_B;

  // pointer view: upper bits forced to one, low bits from the register
  always_comb begin
    ptr_view = '1;
    ptr_view[ADDR_W-1:0] = ptr_q;
  end

  // read path
  always_comb begin
    case (rd_region)
      RG_RAM:  rd_data = ram_rd;
      RG_PTR:  rd_data = ptr_view;
      RG_EXT:  rd_data = ext_rd_data;
      default: rd_data = '0;
    endcase
  end
  assign ext_rd_addr = rd_eff;

  // write path: current value for read-modify-write
  always_comb begin
    case (wr_region)
      RG_RAM:  wr_cur = ram_wcur;
      RG_PTR:  wr_cur = ptr_view;
      RG_EXT:  wr_cur = ext_wr_cur;
      default: wr_cur = '0;
    endcase
  end

  always_comb begin
    bit_mask = '0;
    bit_mask[bit_idx] = 1'b1;
    case (wop_e'(wr_op))
      OP_STORE: wr_new = wr_data;
      OP_SET:   wr_new = wr_cur | bit_mask;
      OP_CLR:   wr_new = wr_cur & ~bit_mask;
      default:  wr_new = wr_cur;
    endcase
  end

  assign wr_act      = (wr_op != OP_IDLE);
  assign ram_we      = wr_act && (wr_region == RG_RAM);
  assign ptr_load    = wr_act && (wr_region == RG_PTR);
  assign ext_wr_en   = wr_act && (wr_region == RG_EXT);
  assign ext_wr_addr = wr_eff;
  assign ext_wr_data = wr_new;

  dmem_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load),
    .din(wr_new[ADDR_W-1:0]), .q(ptr_q)
  );

  dmem_gpram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .widx(wr_off[IDX_W-1:0]),
    .din(wr_new), .ra_idx(rd_off[IDX_W-1:0]), .ra_dout(ram_rd),
    .rb_idx(wr_off[IDX_W-1:0]), .rb_dout(ram_wcur)
  );

  p_ptr_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_region == RG_PTR) |-> rd_data[DATA_W-1]);

  p_hole_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_region == RG_RSV || rd_region == RG_NULL) |-> (rd_data == '0));

  p_null_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_region == RG_NULL) |=> $stable(ptr_q));

  p_ext_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |-> (ext_wr_addr >= EXT_LO[ADDR_W-1:0] && ext_wr_addr <= EXT_HI[ADDR_W-1:0]));
endmodule

// File: tb/dmem_map_test.sv
module dmem_map_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] wr_op = 2'b00;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] bit_idx = '0;
  logic [6:0] ext_rd_addr, ext_wr_addr;
  logic [7:0] ext_rd_data, ext_wr_cur, ext_wr_data;
  logic       ext_wr_en;
  logic [7:0] ext_regs [32];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  assign ext_rd_data = ext_regs[ext_rd_addr[4:0]];
  assign ext_wr_cur  = ext_regs[ext_wr_addr[4:0]];
  always @(posedge clk) if (ext_wr_en) ext_regs[ext_wr_addr[4:0]] <= ext_wr_data;

  dmem_map uut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] op, logic [6:0] a, logic [7:0] d, logic [2:0] b);
    @(negedge clk);
    wr_op = op; wr_addr = a; wr_data = d; bit_idx = b;
    @(negedge clk);
    wr_op = 2'b00;
  endtask

  task automatic rd(logic [6:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(7'h01, v); check("R4 reset ptr readback", v, 8'h80);
    rd(7'h00, v); check("R3 read 00H with ptr 0", v, 8'h00);
  endtask

  task automatic t_direct;
    logic [7:0] v;
    wr(2'b01, 7'h40, 8'h3C, 0); wr(2'b01, 7'h7F, 8'hC3, 0);
    rd(7'h40, v); check("R1 ram 40H", v, 8'h3C);
    rd(7'h7F, v); check("R1 ram 7FH", v, 8'hC3);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    wr(2'b01, 7'h01, 8'h52, 0);
    rd(7'h01, v); check("R4 ptr bit7 forced", v, 8'hD2);
    wr(2'b01, 7'h01, 8'hFF, 0);
    rd(7'h01, v); check("R4 ptr keeps 6:0", v, 8'hFF);
  endtask

  task automatic t_indirect;
    logic [7:0] v;
    wr(2'b01, 7'h01, 8'h55, 0);
    wr(2'b01, 7'h00, 8'hA7, 0);
    rd(7'h55, v); check("R2 indirect write lands", v, 8'hA7);
    wr(2'b01, 7'h40, 8'h19, 0);
    wr(2'b01, 7'h01, 8'h40, 0);
    rd(7'h00, v); check("R2 indirect read", v, 8'h19);
  endtask

  task automatic t_selfref;
    logic [7:0] v;
    wr(2'b01, 7'h01, 8'h00, 0);
    wr(2'b01, 7'h00, 8'h6E, 0);
    rd(7'h01, v); check("R3 self write leaves ptr", v, 8'h80);
    rd(7'h00, v); check("R3 self read zero", v, 8'h00);
    rd(7'h55, v); check("R3 self write leaves ram", v, 8'hA7);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    wr(2'b01, 7'h20, 8'hFF, 0);
    rd(7'h20, v); check("R5 reserved 20H", v, 8'h00);
    wr(2'b10, 7'h3F, 8'h00, 3);
    rd(7'h3F, v); check("R5 reserved 3FH", v, 8'h00);
  endtask

  task automatic t_external;
    logic [7:0] v;
    rd(7'h0B, v); check("R6 ext read", v, 8'h22);
    @(negedge clk);
    wr_op = 2'b01; wr_addr = 7'h12; wr_data = 8'h9D;
    #1 check("R6 ext strobe", {7'd0, ext_wr_en}, 8'h01);
    @(negedge clk); wr_op = 2'b00;
    #1 check("R6 strobe drops", {7'd0, ext_wr_en}, 8'h00);
    rd(7'h12, v); check("R6 ext write data", v, 8'h9D);
    wr(2'b01, 7'h45, 8'h11, 0);
    #1 check("R6 no strobe for ram", {7'd0, ext_wr_en}, 8'h00);
    wr(2'b11, 7'h12, 8'h00, 0);
    rd(7'h12, v); check("R6 R7 ext bit clear", v, 8'h9C);
  endtask

  task automatic t_bitops;
    logic [7:0] v;
    wr(2'b01, 7'h60, 8'h81, 0);
    wr(2'b10, 7'h60, 8'hFF, 4);
    rd(7'h60, v); check("R7 bit set", v, 8'h91);
    wr(2'b11, 7'h60, 8'h00, 7);
    rd(7'h60, v); check("R7 bit clear", v, 8'h11);
    wr(2'b01, 7'h01, 8'h60, 0);
    wr(2'b10, 7'h00, 8'h00, 1);
    rd(7'h60, v); check("R8 indirect set", v, 8'h13);
    wr(2'b11, 7'h00, 8'h00, 0);
    rd(7'h60, v); check("R8 indirect clear", v, 8'h12);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(2'b01, 7'h01, 8'h45, 0);
    @(negedge clk);
    wr_op = 2'b01; wr_addr = 7'h00; wr_data = 8'hEE; rd_addr = 7'h45;
    #1 check("R9 same cycle old value", rd_data, 8'h11);
    @(negedge clk); wr_op = 2'b00;
    #1 check("R9 next cycle new value", rd_data, 8'hEE);
    @(negedge clk);
    wr_op = 2'b01; wr_addr = 7'h01; wr_data = 8'h60; rd_addr = 7'h00;
    #1 check("R9 indirect uses old ptr", rd_data, 8'hEE);
    @(negedge clk); wr_op = 2'b00;
    #1 check("R9 indirect uses new ptr", rd_data, 8'h12);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) ext_regs[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_direct;
    t_pointer;
    t_indirect;
    t_selfref;
    t_reserved;
    t_external;
    t_bitops;
    t_collide;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule